// File: doc/BRIEF.md
# Periodic Interrupt Rate Divider

This block turns a 32.768 kHz time base into periodic interrupt ticks. The time base reaches it as a one-cycle enable strobe in the system clock domain. Each strobe advances a free-running 15-bit count. A 4-bit rate selector picks the tick period, which is a power of two of base cycles. The ticks go to the status logic elsewhere in the chip.

A tick is a single system-clock pulse. It appears on the cycle after a base strobe whose new count value is a multiple of the selected period. The tick is also gated by a separate periodic-enable input. The count runs whatever the rate setting is, so ticks always fall on period boundaries of one shared count. They are not timed from the moment the setting was written, and a change of rate or enable applies at the very next strobe.

Top module: `periodic_rate_divider`

## Requirements
- R1: Synchronous active-low reset clears the count to 0 and holds `tick_o` low. The base strobe has no effect while reset is held. After release, the first strobe brings the count to 1.
- R2: A rate selector value of 0 produces no ticks, whatever the other inputs are.
- R3: While `irq_enable` is 0, no ticks are produced.
- R4: For a selector value n from 3 to 15, a tick follows every strobe whose new count value is a multiple of 2^(n-1).
- R5: Selector values 1 and 2 are remapped to slower rates, with periods of 128 and 256 strobes. These equal 2^(n+6).
- R6: Tick placement follows the shared count since reset. It does not depend on when the selector or the enable last changed. Strobes may arrive with any spacing.
- R7: A new selector value or enable value applies to the strobe sampled in the same cycle. There is no extra latency.
- R8: `tick_o` is high for exactly one cycle, and only on the cycle after a cycle in which `base_en` was 1.
- R9: The count wraps modulo 2^15. Ticks stay aligned across the wrap, so count value 0 counts as a multiple of every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_en | input | 1 | One-cycle strobe per 32.768 kHz base period |
| rate_code | input | 4 | Period selector, 0 = off |
| irq_enable | input | 1 | Periodic tick gate |
| tick_o | output | 1 | One-cycle periodic tick |

## Verification
Three events can fall on the same strobe: a change of selector or enable, the count crossing a period boundary, and the count wrapping to zero. The bench provokes the first two together by changing the selector mid-run. It also runs a random phase in which selector, enable and strobe spacing change under random control. A slow-rate run provokes the wrap. For every cycle, the bench computes the expected tick from its own strobe count and the inputs driven in that cycle. So a setting change that lands on a boundary strobe is judged against the new setting.

// File: rtl/prd_pkg.sv
// Package: shared sizing for the periodic rate divider.
// Assumes a 4-bit selector and a 15-bit base count.
package prd_pkg;
    localparam int PRD_CODE_W    = 4;
    localparam int PRD_CNT_W     = 15;
    localparam int PRD_SLOW_ADD  = 7;   // offset applied to remapped codes
    localparam int PRD_REMAP_MAX = 2;   // highest code that is remapped

    // Decoded rate setting handed from decoder to tick stage
    typedef struct packed {
        logic                 active;
        logic [PRD_CNT_W-1:0] mask;
    } prd_rate_t;
endpackage

// File: rtl/prd_base_counter.sv
// Module: free-running count of base strobes.
// Assumes base_en is a one-cycle strobe in the clk domain; wraps modulo 2^CNT_W.
module prd_base_counter #(
    parameter int CNT_W = prd_pkg::PRD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);
    // Value the count takes at this edge
    always_comb begin
        cnt_next = base_en ? cnt_q + CNT_W'(1) : cnt_q;
    end

    // Count register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end
endmodule

// File: rtl/prd_rate_decoder.sv
// Module: turns the selector and enable into a boundary mask.
// Assumes the selector is sampled combinationally, so changes apply at once.
// Low codes up to REMAP_MAX are shifted up by SLOW_ADD.
module prd_rate_decoder
    import prd_pkg::*;
#(
    parameter int CODE_W    = PRD_CODE_W,
    parameter int CNT_W     = PRD_CNT_W,
    parameter int SLOW_ADD  = PRD_SLOW_ADD,
    parameter int REMAP_MAX = PRD_REMAP_MAX
) (
    input  logic [CODE_W-1:0] rate_code,
    input  logic              irq_enable,
    output prd_rate_t         rate_o
);
    localparam int EFF_W = CODE_W + 1;

    logic [EFF_W-1:0] eff_code;
    logic [EFF_W-1:0] shift_amt;

    // Remap the lowest nonzero codes to slower rates
    always_comb begin
        if (rate_code != '0 && int'(rate_code) <= REMAP_MAX)
            eff_code = EFF_W'(rate_code) + EFF_W'(SLOW_ADD);
        else
            eff_code = EFF_W'(rate_code);
        shift_amt = (eff_code == '0) ? '0 : eff_code - EFF_W'(1);
    end

    // One mask bit per count bit: set below the period exponent
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign rate_o.mask[g] = (32'(g) < 32'(shift_amt));
    end

    // Tick generation needs a nonzero code and the enable
    assign rate_o.active = irq_enable && (rate_code != '0);
endmodule

// File: rtl/prd_tick_gen.sv
// Module: registers a one-cycle tick when a strobe lands the count on a boundary.
// Assumes mask holds ones in the bits that must be zero at a boundary.
module prd_tick_gen
    import prd_pkg::*;
#(
    parameter int CNT_W = PRD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    input  logic [CNT_W-1:0] cnt_next,
    input  prd_rate_t        rate_i,
    output logic             tick_q
);
    logic on_boundary;

    // Boundary test on the count value after this strobe
    always_comb begin
        on_boundary = (cnt_next & rate_i.mask) == '0;
    end

    // Tick register
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= base_en && rate_i.active && on_boundary;
    end
endmodule

// File: rtl/periodic_rate_divider.sv
// Module: top of the periodic interrupt rate divider.
// Assumes base_en is synchronous to clk and no wider than one cycle.
// Output tick lags the qualifying strobe by one cycle.
module periodic_rate_divider
    import prd_pkg::*;
#(
    parameter int CODE_W    = PRD_CODE_W,
    parameter int CNT_W     = PRD_CNT_W,
    parameter int SLOW_ADD  = PRD_SLOW_ADD,
    parameter int REMAP_MAX = PRD_REMAP_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              irq_enable,
    output logic              tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    prd_rate_t        rate;

    prd_base_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_en  (base_en),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next)
    );

    prd_rate_decoder #(
        .CODE_W    (CODE_W),
        .CNT_W     (CNT_W),
        .SLOW_ADD  (SLOW_ADD),
        .REMAP_MAX (REMAP_MAX)
    ) u_dec (
        .rate_code  (rate_code),
        .irq_enable (irq_enable),
        .rate_o     (rate)
    );

    prd_tick_gen #(.CNT_W(CNT_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_en  (base_en),
        .cnt_next (cnt_next),
        .rate_i   (rate),
        .tick_q   (tick_o)
    );
endmodule

// File: rtl/prd_checker.sv
// Module: temporal checks on the rate divider, bound to its top.
module prd_checker #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              base_en,
    input logic [CODE_W-1:0] rate_code,
    input logic              irq_enable,
    input logic              tick_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  mask
);
    // R8: a tick only follows a strobe
    p_tick_after_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(base_en));

    // R8: a tick lasts one cycle
    p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R2: selector zero gives no tick
    p_code_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> ($past(rate_code) != '0));

    // R3: enable low gives no tick
    p_gate_low_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(irq_enable));

    // R6: a tick sits on a period boundary of the registered count
    p_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> ((cnt_q & $past(mask)) == '0));

    // R1: the count holds without a strobe
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !base_en |=> $stable(cnt_q));
endmodule

bind periodic_rate_divider prd_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_en    (base_en),
    .rate_code  (rate_code),
    .irq_enable (irq_enable),
    .tick_o     (tick_o),
    .cnt_q      (cnt_q),
    .mask       (rate.mask)
);

// File: tb/periodic_rate_divider_tb.sv
module periodic_rate_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_en = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       irq_enable = 1'b0;
    logic       tick_o;

    int  n_tests = 0;
    int  n_fail = 0;
    int  model_cnt = 0;
    logic exp_tick = 1'b0;
    bit  done = 0;

    always #2 clk = ~clk;  // 250 MHz

    periodic_rate_divider u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_en    (base_en),
        .rate_code  (rate_code),
        .irq_enable (irq_enable),
        .tick_o     (tick_o)
    );

    // Period in strobes, from R4/R5
    function automatic int period_of(input logic [3:0] c);
        if (c == 4'd1) return 128;
        if (c == 4'd2) return 256;
        return 1 << (int'(c) - 1);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: tick_o=%0b expected=%0b (strobes=%0d)", tag, act, exp, model_cnt);
        end
    endtask

    // Check last cycle's result, then drive one cycle and predict it
    task automatic step(input logic b, input logic [3:0] c, input logic p, input string tag);
        @(negedge clk);
        check(tick_o, exp_tick, tag);
        base_en = b; rate_code = c; irq_enable = p;
        if (b) begin
            model_cnt = (model_cnt + 1) % 32768;
            exp_tick = p && (c != 4'd0) && ((model_cnt % period_of(c)) == 0);
        end else begin
            exp_tick = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset holds tick low and ignores strobes
        rst_n = 1'b0; base_en = 1'b1; rate_code = 4'd3; irq_enable = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(tick_o, 1'b0, "R1 reset");
        end
        @(negedge clk);
        rst_n = 1'b1; base_en = 1'b0; model_cnt = 0; exp_tick = 1'b0;
        // R1/R4: first ticks after reset at strobe 4, 8 (code 3)
        for (int i = 0; i < 40; i++) step(1'b1, 4'd3, 1'b1, "R1 R4 after reset");
        // R4: every code from 3 to 15
        for (int c = 3; c <= 15; c++)
            for (int i = 0; i < period_of(4'(c)) + 9; i++)
                step(1'b1, 4'(c), 1'b1, "R4 period");
        // R5: remapped slow codes
        for (int i = 0; i < 600; i++) step(1'b1, 4'd1, 1'b1, "R5 code 1");
        for (int i = 0; i < 700; i++) step(1'b1, 4'd2, 1'b1, "R5 code 2");
        // R2: code zero silent
        for (int i = 0; i < 1000; i++) step(1'b1, 4'd0, 1'b1, "R2 code zero");
        // R3: enable low silent
        for (int i = 0; i < 1000; i++) step(1'b1, 4'd3, 1'b0, "R3 gate low");
        // R7: mid-run changes apply at once
        for (int i = 0; i < 300; i++) step(1'b1, 4'd10, 1'b1, "R7 before change");
        for (int i = 0; i < 50; i++)  step(1'b1, 4'd3, 1'b1, "R7 after change");
        for (int i = 0; i < 50; i++)  step(1'b1, 4'd4, (i % 7) != 3, "R7 gate toggle");
        // R6/R8: random strobe spacing and settings
        begin
            logic [3:0] c = 4'd4;
            logic p = 1'b1;
            for (int i = 0; i < 20000; i++) begin
                if (($urandom % 150) == 0) begin
                    c = 4'($urandom % 10);
                    p = ($urandom % 5) != 0;
                end
                step(($urandom % 3) == 0, c, p, "R6 R8 random");
            end
        end
        // R9: cross the count wrap with slowest and a fast rate
        for (int i = 0; i < 40000; i++) step(1'b1, 4'd15, 1'b1, "R9 wrap slow");
        for (int i = 0; i < 33000; i++) step(1'b1, 4'd12, 1'b1, "R9 wrap");
        step(1'b0, 4'd3, 1'b1, "R8 idle");
        step(1'b0, 4'd3, 1'b1, "R8 idle");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule